// File: doc/BRIEF.md
# Segmented DAC Thermometer Decoder

This block is the digital front end of a dual-channel 14-bit current-steering converter. On each rising clock edge every channel captures a parallel input word, then splits it into three groups. The top five bits become 31 equal-weight thermometer select lines. The next four bits become 15 equal-weight thermometer lines, each worth one sixteenth of an upper line. The bottom five bits drive binary-weighted cells directly.

Each select line leaves the block as a matched complementary pair. The true rail steers its cell to output node A and the inverted rail steers it to node B. A second register stage sits behind the decoders, so every select of a channel changes on the same edge. The two channels share only the clock and reset, and they accept a new word every cycle.

Top module: `segdec_dual`

## Requirements
- R1: An input word sampled at a rising edge shows up on the outputs after the following rising edge, a fixed latency of two cycles. A new word is accepted on every clock.
- R2: Input bits [13:9] form the upper value u (0..31). Upper true line k (k = 0..30) is high exactly when u > k, so u asserts the u lowest lines.
- R3: Input bits [8:5] form the middle value m (0..15). Middle true line k (k = 0..14) is high exactly when m > k.
- R4: Input bits [4:0] pass to the 5-bit low true output unchanged. Bit i carries weight 2^i.
- R5: Every B rail is the bitwise complement of its A rail, on the upper, middle and low outputs alike.
- R6: The steered weight of the A rails equals the input code for every code from 0 to 16383. Each upper line weighs 512, each middle line 32, and the low bits their binary weight.
- R7: Each channel's outputs depend only on that channel's own input word.
- R8: A synchronous active-high reset clears both register stages. From the first edge with reset high, every A rail is 0 and every B rail is 1, which steers all cells to node B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0Data | input | 14 | Channel 0 input word |
| ch1Data | input | 14 | Channel 1 input word |
| ch0UpperA | output | 31 | Channel 0 upper thermometer, A rail |
| ch0UpperB | output | 31 | Channel 0 upper thermometer, B rail |
| ch0MidA | output | 15 | Channel 0 middle thermometer, A rail |
| ch0MidB | output | 15 | Channel 0 middle thermometer, B rail |
| ch0LowA | output | 5 | Channel 0 binary cells, A rail |
| ch0LowB | output | 5 | Channel 0 binary cells, B rail |
| ch1UpperA | output | 31 | Channel 1 upper thermometer, A rail |
| ch1UpperB | output | 31 | Channel 1 upper thermometer, B rail |
| ch1MidA | output | 15 | Channel 1 middle thermometer, A rail |
| ch1MidB | output | 15 | Channel 1 middle thermometer, B rail |
| ch1LowA | output | 5 | Channel 1 binary cells, A rail |
| ch1LowB | output | 5 | Channel 1 binary cells, B rail |

## Verification
The properties assume three things:
- Reset is high from the first clock, so both register stages hold defined values before any check applies.
- Both input words are known values on every edge.
- The latency check applies only when two reset-free edges have passed.

The bench holds reset from time zero and drives both channels with a fully defined word on every falling edge. It exercises a mid-stream reset and afterwards accounts for the cleared stages as code zero.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int DataW      = 14;
  localparam int UpperW     = 5;
  localparam int MidW       = 4;
  localparam int LowW       = DataW - UpperW - MidW;
  localparam int UpperLines = (1 << UpperW) - 1;
  localparam int MidLines   = (1 << MidW) - 1;
  localparam int NumCh      = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearStage;
    logic loadStage;
  } segStrobe_t;
endpackage

// File: rtl/segdec_thermo.sv
module segdec_thermo #(
  parameter int W = 4,
  localparam int Lines = (1 << W) - 1
) (
  input  logic [W-1:0]     val,
  output logic [Lines-1:0] lines
);
  for (genvar k = 0; k < Lines; k++) begin : g_line
    assign lines[k] = (int'(val) > k);
  end
endmodule

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic       rst,
  output segStrobe_t strobe
);
  always_comb begin
    strobe.clearStage = rst;
    strobe.loadStage  = !rst;
  end
endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
(
  input  logic                  clk,
  input  segStrobe_t            strobe,
  input  logic [DataW-1:0]      dIn,
  output logic [UpperLines-1:0] upperA,
  output logic [UpperLines-1:0] upperB,
  output logic [MidLines-1:0]   midA,
  output logic [MidLines-1:0]   midB,
  output logic [LowW-1:0]       lowA,
  output logic [LowW-1:0]       lowB
);
  localparam int MidLo   = LowW;
  localparam int UpperLo = LowW + MidW;

  logic [DataW-1:0]      wordQ;
  logic [UpperLines-1:0] upperDec;
  logic [MidLines-1:0]   midDec;

  // Stage 1: input capture
  always_ff @(posedge clk) begin
    if (strobe.clearStage)     wordQ <= '0;
    else if (strobe.loadStage) wordQ <= dIn;
  end

  segdec_thermo #(.W(UpperW)) uUpper (
    .val  (wordQ[UpperLo +: UpperW]),
    .lines(upperDec)
  );

  segdec_thermo #(.W(MidW)) uMid (
    .val  (wordQ[MidLo +: MidW]),
    .lines(midDec)
  );

  // Stage 2: aligned complementary selects
  always_ff @(posedge clk) begin
    if (strobe.clearStage) begin
      upperA <= '0;
      upperB <= '1;
      midA   <= '0;
      midB   <= '1;
      lowA   <= '0;
      lowB   <= '1;
    end else if (strobe.loadStage) begin
      upperA <= upperDec;
      upperB <= ~upperDec;
      midA   <= midDec;
      midB   <= ~midDec;
      lowA   <= wordQ[LowW-1:0];
      lowB   <= ~wordQ[LowW-1:0];
    end
  end
endmodule

// File: rtl/segdec_dual.sv
module segdec_dual
  import segdec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DataW-1:0]      ch0Data,
  input  logic [DataW-1:0]      ch1Data,
  output logic [UpperLines-1:0] ch0UpperA,
  output logic [UpperLines-1:0] ch0UpperB,
  output logic [MidLines-1:0]   ch0MidA,
  output logic [MidLines-1:0]   ch0MidB,
  output logic [LowW-1:0]       ch0LowA,
  output logic [LowW-1:0]       ch0LowB,
  output logic [UpperLines-1:0] ch1UpperA,
  output logic [UpperLines-1:0] ch1UpperB,
  output logic [MidLines-1:0]   ch1MidA,
  output logic [MidLines-1:0]   ch1MidB,
  output logic [LowW-1:0]       ch1LowA,
  output logic [LowW-1:0]       ch1LowB
);
  segStrobe_t strobe;

  logic [DataW-1:0]      dIn    [NumCh];
  logic [UpperLines-1:0] upA    [NumCh];
  logic [UpperLines-1:0] upB    [NumCh];
  logic [MidLines-1:0]   mdA    [NumCh];
  logic [MidLines-1:0]   mdB    [NumCh];
  logic [LowW-1:0]       loA    [NumCh];
  logic [LowW-1:0]       loB    [NumCh];

  segdec_ctrl uCtrl (
    .rst   (rst),
    .strobe(strobe)
  );

  assign dIn[0] = ch0Data;
  assign dIn[1] = ch1Data;

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    segdec_datapath uPath (
      .clk   (clk),
      .strobe(strobe),
      .dIn   (dIn[c]),
      .upperA(upA[c]),
      .upperB(upB[c]),
      .midA  (mdA[c]),
      .midB  (mdB[c]),
      .lowA  (loA[c]),
      .lowB  (loB[c])
    );
  end

  assign ch0UpperA = upA[0];
  assign ch0UpperB = upB[0];
  assign ch0MidA   = mdA[0];
  assign ch0MidB   = mdB[0];
  assign ch0LowA   = loA[0];
  assign ch0LowB   = loB[0];
  assign ch1UpperA = upA[1];
  assign ch1UpperB = upB[1];
  assign ch1MidA   = mdA[1];
  assign ch1MidB   = mdB[1];
  assign ch1LowA   = loA[1];
  assign ch1LowB   = loB[1];
endmodule

// File: rtl/segdec_dual_chk.sv
module segdec_dual_chk
  import segdec_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [DataW-1:0]      ch0Data,
  input logic [DataW-1:0]      ch1Data,
  input logic [UpperLines-1:0] ch0UpperA,
  input logic [UpperLines-1:0] ch0UpperB,
  input logic [MidLines-1:0]   ch0MidA,
  input logic [MidLines-1:0]   ch0MidB,
  input logic [LowW-1:0]       ch0LowA,
  input logic [LowW-1:0]       ch0LowB,
  input logic [UpperLines-1:0] ch1UpperA,
  input logic [UpperLines-1:0] ch1UpperB,
  input logic [MidLines-1:0]   ch1MidA,
  input logic [MidLines-1:0]   ch1MidB,
  input logic [LowW-1:0]       ch1LowA,
  input logic [LowW-1:0]       ch1LowB
);
  localparam int UpperWt = 1 << (MidW + LowW);
  localparam int MidWt   = 1 << LowW;

  // R5: complementary rails
  p_complement_r5: assert property (@(posedge clk) disable iff (rst)
    (ch0UpperB == ~ch0UpperA) && (ch0MidB == ~ch0MidA) && (ch0LowB == ~ch0LowA) &&
    (ch1UpperB == ~ch1UpperA) && (ch1MidB == ~ch1MidA) && (ch1LowB == ~ch1LowA));

  // R8: reset steers every cell to node B
  p_reset_steer_r8: assert property (@(posedge clk)
    rst |=> (ch0UpperA == '0) && (ch0MidA == '0) && (ch0LowA == '0) &&
            (ch0UpperB == '1) && (ch0MidB == '1) && (ch0LowB == '1) &&
            (ch1UpperA == '0) && (ch1MidA == '0) && (ch1LowA == '0) &&
            (ch1UpperB == '1) && (ch1MidB == '1) && (ch1LowB == '1));

  // R2: upper lines contiguous from line 0
  p_upper_shape_r2: assert property (@(posedge clk) disable iff (rst)
    ((ch0UpperA & (ch0UpperA + UpperLines'(1))) == '0) &&
    ((ch1UpperA & (ch1UpperA + UpperLines'(1))) == '0));

  // R3: middle lines contiguous from line 0
  p_mid_shape_r3: assert property (@(posedge clk) disable iff (rst)
    ((ch0MidA & (ch0MidA + MidLines'(1))) == '0) &&
    ((ch1MidA & (ch1MidA + MidLines'(1))) == '0));

  // R1, R6, R7: channel 0 weight equals its own word two edges back
  p_weight_ch0_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |->
      (int'($countones(ch0UpperA)) * UpperWt + int'($countones(ch0MidA)) * MidWt
       + int'(ch0LowA) == int'($past(ch0Data, 2))));

  // R1, R6, R7: channel 1 weight equals its own word two edges back
  p_weight_ch1_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |->
      (int'($countones(ch1UpperA)) * UpperWt + int'($countones(ch1MidA)) * MidWt
       + int'(ch1LowA) == int'($past(ch1Data, 2))));
endmodule

bind segdec_dual segdec_dual_chk uChk (
  .clk(clk), .rst(rst), .ch0Data(ch0Data), .ch1Data(ch1Data),
  .ch0UpperA(ch0UpperA), .ch0UpperB(ch0UpperB), .ch0MidA(ch0MidA),
  .ch0MidB(ch0MidB), .ch0LowA(ch0LowA), .ch0LowB(ch0LowB),
  .ch1UpperA(ch1UpperA), .ch1UpperB(ch1UpperB), .ch1MidA(ch1MidA),
  .ch1MidB(ch1MidB), .ch1LowA(ch1LowA), .ch1LowB(ch1LowB)
);

// File: tb/segdec_dual_test.sv
module segdec_dual_test;
  localparam int ClkPeriod = 8;
  localparam int WatchdogCycles = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] ch0Data = '0;
  logic [13:0] ch1Data = '0;
  logic [30:0] ch0UpperA, ch0UpperB, ch1UpperA, ch1UpperB;
  logic [14:0] ch0MidA, ch0MidB, ch1MidA, ch1MidB;
  logic [4:0]  ch0LowA, ch0LowB, ch1LowA, ch1LowB;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [13:0] hist0 [2];
  logic [13:0] hist1 [2];
  logic [13:0] heldCh1 = 14'h2A5A;
  logic [30:0] heldUpper = '0;
  bit indepPhase = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  segdec_dual uut (.*);

  function automatic logic [30:0] therm31(input int v);
    logic [30:0] r;
    for (int k = 0; k < 31; k++) r[k] = (v > k);
    return r;
  endfunction

  function automatic logic [14:0] therm15(input int v);
    logic [14:0] r;
    for (int k = 0; k < 15; k++) r[k] = (v > k);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkCh(input int ch, input logic [13:0] code,
                         input logic [30:0] uA, input logic [30:0] uB,
                         input logic [14:0] mA, input logic [14:0] mB,
                         input logic [4:0] lA, input logic [4:0] lB);
    int wt;
    // R1: output compared with the word driven two edges earlier
    check(uA == therm31(int'(code[13:9])), "R2", $sformatf("ch%0d upper", ch), uA, therm31(int'(code[13:9])));
    check(mA == therm15(int'(code[8:5])), "R3", $sformatf("ch%0d mid", ch), mA, therm15(int'(code[8:5])));
    check(lA == code[4:0], "R4", $sformatf("ch%0d low", ch), lA, code[4:0]);
    check((uB == ~uA) && (mB == ~mA) && (lB == ~lA), "R5", $sformatf("ch%0d B rail", ch),
          {uB, mB, lB}, {~uA, ~mA, ~lA});
    wt = $countones(uA) * 512 + $countones(mA) * 32 + int'(lA);
    check(wt == int'(code), "R6", $sformatf("ch%0d weight (R1 latency)", ch), wt, code);
  endtask

  task automatic step(input logic [13:0] a, input logic [13:0] b);
    @(negedge clk);
    checkCh(0, hist0[1], ch0UpperA, ch0UpperB, ch0MidA, ch0MidB, ch0LowA, ch0LowB);
    checkCh(1, hist1[1], ch1UpperA, ch1UpperB, ch1MidA, ch1MidB, ch1LowA, ch1LowB);
    if (indepPhase)  // R7: channel 1 untouched while channel 0 sweeps
      check(ch1UpperA == heldUpper, "R7", "ch1 steady under ch0 sweep", ch1UpperA, heldUpper);
    hist0[1] = hist0[0]; hist0[0] = a;
    hist1[1] = hist1[0]; hist1[0] = b;
    ch0Data = a;
    ch1Data = b;
  endtask

  task automatic checkReset();
    check((ch0UpperA == '0) && (ch0MidA == '0) && (ch0LowA == '0) &&
          (ch1UpperA == '0) && (ch1MidA == '0) && (ch1LowA == '0), "R8", "A rails cleared",
          {ch0UpperA, ch0MidA, ch0LowA}, 0);
    check((&ch0UpperB) && (&ch0MidB) && (&ch0LowB) &&
          (&ch1UpperB) && (&ch1MidB) && (&ch1LowB), "R8", "B rails set",
          {ch0UpperB, ch0MidB, ch0LowB}, 51'h7_FFFF_FFFF_FFFF);
  endtask

  task automatic midReset();
    @(negedge clk);
    rst = 1'b1;
    ch0Data = 14'h3FFF;
    ch1Data = 14'h1234;
    @(negedge clk);
    checkReset();
    rst = 1'b0;
    ch0Data = '0;
    ch1Data = '0;
    hist0[0] = '0; hist0[1] = '0;
    hist1[0] = '0; hist1[1] = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WatchdogCycles) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WatchdogCycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [13:0] corners [8];
    void'($urandom(32'd20240611));
    corners = '{14'h0000, 14'h3FFF, 14'h01FF, 14'h0200, 14'h001F, 14'h0020, 14'h3E00, 14'h1E1F};
    hist0[0] = '0; hist0[1] = '0;
    hist1[0] = '0; hist1[1] = '0;

    // R8: reset state
    repeat (3) @(negedge clk);
    checkReset();
    rst = 1'b0;

    // R6: every code on channel 0, channel 1 held (R7)
    heldUpper = therm31(int'(heldCh1[13:9]));
    step(14'd0, heldCh1);
    step(14'd1, heldCh1);
    indepPhase = 1'b1;
    for (int c = 2; c < 16384; c++) step(14'(c), heldCh1);
    indepPhase = 1'b0;

    // R6: every code on channel 1, channel 0 random
    for (int c = 16383; c >= 0; c--) step(14'($urandom), 14'(c));

    // Corners on both channels, crossed
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) step(corners[i], corners[j]);

    midReset();
    for (int i = 0; i < 2000; i++) step(14'($urandom), 14'($urandom));
    midReset();
    step(14'h3FFF, 14'h0000);
    step(14'h0000, 14'h3FFF);
    step('0, '0);
    step('0, '0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule